// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a pulse-width modulated waveform with a resolution of up to 10 bits. Software sets the cycle length and the high time through a small register write port. Each 10-bit value is split into an 8-bit low register and a 2-bit field of a shared high register. A free-running counter advances once per source clock tick, and the output is high while the counter is below the active duty value.

The period and duty values that software writes are master copies. The counter and the comparator only ever use active slave copies. The slaves reload from the masters at the end of a cycle, so a write made mid-cycle never shortens a pulse or a cycle. A shorter period gives a faster waveform with fewer duty steps.

An enable input gates the whole function. While it is low, the pin is held low, the counter rests at zero and the slaves track the masters. Raising the enable therefore starts a clean cycle from the newest settings.

Top module: `pwm10_gen`

## Requirements
- R1: Register addresses are 0 for the period low byte, 1 for the duty low byte and 2 for the high register. High register bits [3:2] are period bits [9:8], and bits [1:0] are duty bits [9:8]. A cycle lasts exactly that 10-bit period value in ticks.
- R2: The counter runs from 0 to period-1 and returns to 0 on the tick that finds it at period-1. A period of 0 behaves as a one-tick cycle, with the counter staying at 0.
- R3: A duty write reaches the output only from the start of the next cycle. The cycle in progress keeps its old duty.
- R4: A period write takes effect only at the next cycle boundary. The cycle in progress is never truncated or stretched.
- R5: While enabled, the output is high while the count is below the active duty and low for the rest of the cycle.
- R6: An active duty greater than or equal to the period keeps the output high for the whole cycle. A duty of 0 keeps it low.
- R7: The counter advances only in clock cycles where tick_i is high. Without a tick, the count and the output hold.
- R8: With en_i low, the output is low and the counter is 0, and the active period and duty follow the masters. After en_i rises, the first cycle starts at count 0.
- R9: After reset, all registers are zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 period low, 1 duty low, 2 high) |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 1 | Source clock tick, one count per high cycle |
| en_i | input | 1 | Output and counter enable |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume that tick_i and en_i are synchronous to clk_i and change only between edges. They also assume the period is changed only through the master registers, so the active period moves only at a wrap or while the block is disabled. The bench drives every input on the falling clock edge and never touches internal state. Every period and duty change goes through the write port: either while disabled or mid-cycle, the latter to exercise the double buffering. The sweep covers periods 0 to 12 against duties 0 to 13, plus one full 10-bit setting.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  typedef enum logic [1:0] {
    ADDR_PRD_LO  = 2'd0,
    ADDR_DUTY_LO = 2'd1,
    ADDR_HIGH    = 2'd2,
    ADDR_NONE    = 2'd3
  } pwm_addr_e;
endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int LOW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  pwm_addr_e        wr_addr_i,
  input  logic [LOW_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] prd_o,
  output logic [CNT_W-1:0] duty_o
);
  localparam int HI_W = CNT_W - LOW_W;

  logic [LOW_W-1:0]  prd_lo_q, duty_lo_q;
  logic [2*HI_W-1:0] high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_lo_q  <= '0;
      duty_lo_q <= '0;
      high_q    <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_PRD_LO:  prd_lo_q  <= wr_data_i;
        ADDR_DUTY_LO: duty_lo_q <= wr_data_i;
        ADDR_HIGH:    high_q    <= wr_data_i[2*HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign prd_o  = {high_q[2*HI_W-1:HI_W], prd_lo_q};
  assign duty_o = {high_q[HI_W-1:0], duty_lo_q};
endmodule

// File: rtl/pwm10_core.sv
module pwm10_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] prd_mst_i,
  input  logic [CNT_W-1:0] duty_mst_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] prd_act_o,
  output logic [CNT_W-1:0] duty_act_o
);
  logic [CNT_W-1:0] cnt_q, prd_q, duty_q;
  logic [CNT_W:0]   cnt_inc;
  logic             wrap;

  // last count of the cycle; period 0 wraps every tick
  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign wrap    = cnt_inc >= {1'b0, prd_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prd_q  <= '0;
      duty_q <= '0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      prd_q  <= prd_mst_i;
      duty_q <= duty_mst_i;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        prd_q  <= prd_mst_i;
        duty_q <= duty_mst_i;
      end else begin
        cnt_q  <= cnt_inc[CNT_W-1:0];
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign prd_act_o  = prd_q;
  assign duty_act_o = duty_q;
endmodule

// File: rtl/pwm10_cmp.sv
module pwm10_cmp #(
  parameter int CNT_W = 10
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  assign pwm_o = en_i & (cnt_i < duty_i);
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int LOW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [LOW_W-1:0] wr_data_i,
  input  logic             tick_i,
  input  logic             en_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] prd_mst_w, duty_mst_w;
  logic [CNT_W-1:0] cnt_w, prd_act_w, duty_act_w;

  pwm10_regs #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (pwm_addr_e'(wr_addr_i)),
    .wr_data_i (wr_data_i),
    .prd_o     (prd_mst_w),
    .duty_o    (duty_mst_w)
  );

  pwm10_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (en_i),
    .prd_mst_i  (prd_mst_w),
    .duty_mst_i (duty_mst_w),
    .cnt_o      (cnt_w),
    .prd_act_o  (prd_act_w),
    .duty_act_o (duty_act_w)
  );

  pwm10_cmp #(.CNT_W(CNT_W)) u_cmp (
    .en_i   (en_i),
    .cnt_i  (cnt_w),
    .duty_i (duty_act_w),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/pwm10_gen_chk.sv
module pwm10_gen_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] prd_act_q,
  input logic [CNT_W-1:0] duty_act_q
);
  a_r2_cnt_below_prd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_act_q != '0) |-> (cnt_q < prd_act_q));

  a_r2_zero_prd_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_act_q == '0) |-> (cnt_q == '0));

  a_r3_duty_only_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(duty_act_q));

  a_r4_prd_only_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(prd_act_q));

  a_r7_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));

  a_r8_dis_cnt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

bind pwm10_gen pwm10_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tick_i     (tick_i),
  .cnt_q      (cnt_w),
  .prd_act_q  (prd_act_w),
  .duty_act_q (duty_act_w)
);

// File: tb/pwm10_gen_bench.sv
`timescale 1ns/1ps
module pwm10_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic       tick_i = 1'b0;
  logic       en_i = 1'b0;
  logic       pwm_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pwm10_gen u_pwm10_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .tick_i(tick_i), .en_i(en_i), .pwm_o(pwm_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // load masters while disabled, settle slaves
  task automatic cfg(input int p, input int d);
    en_i = 1'b0;
    wr(2'd0, 8'(p & 255));
    wr(2'd1, 8'(d & 255));
    wr(2'd2, {4'b0, 2'((p >> 8) & 3), 2'((d >> 8) & 3)});
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic start();
    en_i = 1'b1; tick_i = 1'b1;
  endtask

  // sample n points from cycle position i0, one tick per clock
  task automatic span(input int p, input int d, input int n, input int i0, input string tag);
    int pe;
    pe = (p < 1) ? 1 : p;
    for (int k = 0; k < n; k++) begin
      #1 chk(pwm_o, ((i0 + k) % pe) < d, tag);
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R9 reset
    #1 chk(pwm_o, 1'b0, "R9 in reset");
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    en_i = 1'b1; tick_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1 chk(pwm_o, 1'b0, "R9 zero regs after reset");
      @(negedge clk_i);
    end

    // R1 R2 R5 R6 sweep, each start from count 0 (R8)
    for (int p = 0; p <= 12; p++) begin
      for (int d = 0; d <= 13; d++) begin
        cfg(p, d);
        start();
        span(p, d, 2 * ((p < 1) ? 1 : p), 0, "R5 R6 R2 sweep");
      end
    end

    // R1 full 10-bit fields: period 1000, duty 700
    cfg(1000, 700);
    start();
    span(1000, 700, 1000, 0, "R1 high register fields");

    // R8 disabled: low regardless of duty
    cfg(8, 5);
    for (int k = 0; k < 5; k++) begin
      #1 chk(pwm_o, 1'b0, "R8 disabled output low");
      @(negedge clk_i);
    end
    start();
    span(8, 5, 3, 0, "R8 run");
    en_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1 chk(pwm_o, 1'b0, "R8 disabled mid cycle");
      @(negedge clk_i);
    end
    start();
    span(8, 5, 8, 0, "R8 restart at zero");

    // R3 duty write mid-cycle
    cfg(8, 3);
    start();
    span(8, 3, 3, 0, "R3 before write");
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 8'd6;
    span(8, 3, 1, 3, "R3 write cycle");
    wr_en_i = 1'b0;
    span(8, 3, 4, 4, "R3 old duty kept");
    span(8, 6, 16, 0, "R3 new duty next cycle");

    // R4 period write mid-cycle
    cfg(8, 2);
    start();
    span(8, 2, 2, 0, "R4 before write");
    wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'd4;
    span(8, 2, 1, 2, "R4 write cycle");
    wr_en_i = 1'b0;
    span(8, 2, 5, 3, "R4 cycle not truncated");
    span(4, 2, 12, 0, "R4 new period");

    // R7 tick hold
    cfg(6, 3);
    start();
    span(6, 3, 2, 0, "R7 run");
    tick_i = 1'b0;
    span(6, 3, 1, 2, "R7 hold high");
    span(6, 3, 1, 2, "R7 hold high");
    span(6, 3, 1, 2, "R7 hold high");
    tick_i = 1'b1;
    span(6, 3, 3, 2, "R7 resume");
    tick_i = 1'b0;
    for (int k = 0; k < 4; k++) span(6, 3, 1, 5, "R7 hold low");
    tick_i = 1'b1;
    span(6, 3, 8, 5, "R7 resume to wrap");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule